// File: doc/BRIEF.md
# Target/Overflow Timer Channel

This block is a single 16-bit counting channel placed on a simple register bus. Software programs three registers: a live count, a compare value (target) and a control word (mode). From one of several tick sources the channel advances its count. It wraps either when the count matches the target or when it passes full scale. Sticky flags in the mode word record these events, and a one-cycle interrupt request goes to an external interrupt controller.

The parameter `CHAN_ID` picks the channel's personality. Channel 0 may follow an external pixel-rate tick. Channel 1 may follow an external line-rate tick. Channel 2 has a divide-by-8 prescaler and a stop control instead. Each channel raises its own bit in the interrupt status vector. Reads return data combinationally in the cycle `bus_rd` is high. Writes take effect at the clock edge that ends the write cycle.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset the count, target and mode registers read 0 and `irq_status` is 0.
- R2: Register addresses are 0 = count, 1 = mode, 2 = target; read data appears on `bus_rdata` while `bus_rd` is high and is 0 otherwise. With the system clock selected the count rises by one at every clock edge.
- R3: With mode bit 3 set, a tick that would bring the count to the target value loads 0 instead and sets mode bit 11.
- R4: With mode bit 3 clear, the count passes through the target (setting bit 11 without wrapping) and wraps from 0xFFFF to 0, setting mode bit 12.
- R5: A target event with mode bit 4 set, or an overflow event with mode bit 5 set, raises `irq_status` for exactly one cycle. It shows value 0x10 shifted left by `CHAN_ID` (0x10, 0x20, 0x40) in the same cycle that the count and flags update.
- R6: With mode bit 6 set every qualifying event interrupts. With it clear, only the first qualifying event after a mode write does.
- R7: A mode read returns the current value, and at that edge bits 11 and 12 clear. An event at the same edge sets its flag anyway.
- R8: A mode write stores the written value with bits 11 and 12 cleared, zeroes the count and the prescaler, and re-arms the one-shot interrupt.
- R9: On channel 2, mode bit 9 advances the count once every 8 clocks and mode bit 0 freezes it. On channels 0 and 1 these bits do not change the count rate.
- R10: On channel 0, mode bit 8 makes the count advance only on `pix_tick` pulses (channel 1: `line_tick`). On channel 2, bit 8 has no effect on the rate.
- R11: A target write leaves the count advancing untouched. A count write loads the 16-bit value and takes priority over a tick at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_tick | input | 1 | External pixel-rate tick (used by channel 0) |
| line_tick | input | 1 | External line-rate tick (used by channel 1) |
| bus_addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| irq_status | output | 8 | One-cycle interrupt pulse carrying the channel's status bit |

## Verification
Count, flags and interrupt pulse all change at the edge that ends the ticking cycle. A register write counts from the edge that ends its strobe cycle, and read data is combinational. A behavioural model in the bench updates at each rising edge. One nanosecond later, the interrupt vector and any read data are compared against it. Explicit reads sample a quarter period after the falling edge, before the edge that would clear the flags, so a mode read shows the pre-clear value. For the divide-by-8 path, the first tick lands 8 edges after the mode write, and the expected counts are worked out on that basis.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        RA_COUNT  = 2'd0,
        RA_MODE   = 2'd1,
        RA_TARGET = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    // control word bit positions
    localparam int MB_STOP     = 0;
    localparam int MB_WRAP_TGT = 3;
    localparam int MB_IRQ_TGT  = 4;
    localparam int MB_IRQ_OVF  = 5;
    localparam int MB_IRQ_RPT  = 6;
    localparam int MB_EXT_SRC  = 8;
    localparam int MB_DIV8     = 9;
    localparam int MB_HIT_TGT  = 11;
    localparam int MB_HIT_OVF  = 12;

    localparam logic [REG_W-1:0] FLAG_MASK = 16'h1800;

    typedef struct packed {
        logic tgt;
        logic ovf;
    } evt_t;

    function automatic logic [7:0] irq_code(input int id);
        return 8'h10 << id;
    endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
`timescale 1ns/1ps
module tmr_tick_sel import tmr_pkg::*; #(
    parameter int CHAN_ID = 0,
    parameter int PRE_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [REG_W-1:0] mode,
    input  logic             pix_tick,
    input  logic             line_tick,
    output logic             tick
);
    generate
        if (CHAN_ID == 2) begin : g_prescaled
            logic [PRE_W-1:0] pre_q;
            logic             stop, div;
            logic             unused_in;
            assign stop = mode[MB_STOP];
            assign div  = mode[MB_DIV8];
            assign unused_in = ^{pix_tick, line_tick, mode[REG_W-1:MB_DIV8+1],
                                 mode[MB_DIV8-1:MB_STOP+1]};

            always_ff @(posedge clk) begin
                if (rst || restart)
                    pre_q <= '0;
                else if (div && !stop)
                    pre_q <= pre_q + 1'b1;
            end

            assign tick = !stop && (!div || (pre_q == '1));

            AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
                (tick && div && !stop && !restart) |=> !tick); // R9
        end else if (CHAN_ID == 0 || CHAN_ID == 1) begin : g_external
            logic ext;
            logic unused_in;
            assign ext  = (CHAN_ID == 0) ? pix_tick : line_tick;
            assign tick = mode[MB_EXT_SRC] ? ext : 1'b1;
            assign unused_in = ^{clk, rst, restart, pix_tick, line_tick,
                                 mode[REG_W-1:MB_EXT_SRC+1], mode[MB_EXT_SRC-1:0]};
        end else begin : g_plain
            logic unused_in;
            assign tick = 1'b1;
            assign unused_in = ^{clk, rst, restart, pix_tick, line_tick, mode};
        end
    endgenerate
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core import tmr_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] target,
    input  logic         wrap_on_tgt,
    output logic [W-1:0] count,
    output evt_t         evt
);
    localparam logic [W-1:0] FULL = '1;

    logic [W-1:0] inc;
    assign inc     = count + 1'b1;
    assign evt.tgt = tick && (inc == target);
    assign evt.ovf = tick && (count == FULL);

    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick) begin
            if (evt.ovf || (evt.tgt && wrap_on_tgt))
                count <= '0;
            else
                count <= inc;
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0)); // R8
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> (count == $past(load_val))); // R11
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear && !load) |=> $stable(count)); // R9
endmodule

// File: rtl/tmr_irq_gen.sv
`timescale 1ns/1ps
module tmr_irq_gen import tmr_pkg::*; #(
    parameter int CHAN_ID = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt,
    input  logic       en_tgt,
    input  logic       en_ovf,
    input  logic       rpt_en,
    input  logic       rearm,
    output logic [7:0] irq_status
);
    localparam logic [7:0] CODE = irq_code(CHAN_ID);

    logic fired_q, want, fire;
    assign want = (evt.tgt && en_tgt) || (evt.ovf && en_ovf);
    assign fire = want && (rpt_en || !fired_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q    <= 1'b0;
            irq_status <= '0;
        end else begin
            irq_status <= fire ? CODE : '0;
            if (rearm)
                fired_q <= 1'b0;
            else if (fire)
                fired_q <= 1'b1;
        end
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (fired_q && !rpt_en && !rearm) |=> (irq_status == '0)); // R6
    AST_IRQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (rst)
        (irq_status != '0) |-> $past(evt.tgt || evt.ovf)); // R5
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel import tmr_pkg::*; #(
    parameter int CHAN_ID = 0,
    parameter int PRE_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_tick,
    input  logic             line_tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic [7:0]       irq_status
);
    reg_addr_e        addr;
    logic             wr_cnt, wr_mode, wr_tgt, rd_mode;
    logic             tick_raw, tick_eff;
    logic [REG_W-1:0] mode_q, target_q, count;
    evt_t             evt;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_cnt  = bus_wr && (addr == RA_COUNT);
    assign wr_mode = bus_wr && (addr == RA_MODE);
    assign wr_tgt  = bus_wr && (addr == RA_TARGET);
    assign rd_mode = bus_rd && (addr == RA_MODE);
    assign tick_eff = tick_raw && !wr_mode && !wr_cnt;

    tmr_tick_sel #(.CHAN_ID(CHAN_ID), .PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst(rst), .restart(wr_mode), .mode(mode_q),
        .pix_tick(pix_tick), .line_tick(line_tick), .tick(tick_raw)
    );

    tmr_count_core #(.W(REG_W)) u_core (
        .clk(clk), .rst(rst), .tick(tick_eff), .clear(wr_mode),
        .load(wr_cnt), .load_val(bus_wdata), .target(target_q),
        .wrap_on_tgt(mode_q[MB_WRAP_TGT]), .count(count), .evt(evt)
    );

    tmr_irq_gen #(.CHAN_ID(CHAN_ID)) u_irq (
        .clk(clk), .rst(rst), .evt(evt),
        .en_tgt(mode_q[MB_IRQ_TGT]), .en_ovf(mode_q[MB_IRQ_OVF]),
        .rpt_en(mode_q[MB_IRQ_RPT]), .rearm(wr_mode), .irq_status(irq_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            target_q <= '0;
        end else begin
            if (wr_tgt)
                target_q <= bus_wdata;
            if (wr_mode)
                mode_q <= bus_wdata & ~FLAG_MASK;
            else begin
                mode_q[MB_HIT_TGT] <= evt.tgt || (mode_q[MB_HIT_TGT] && !rd_mode);
                mode_q[MB_HIT_OVF] <= evt.ovf || (mode_q[MB_HIT_OVF] && !rd_mode);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (addr)
                RA_COUNT:  bus_rdata = count;
                RA_MODE:   bus_rdata = mode_q;
                RA_TARGET: bus_rdata = target_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_TARGET_WRAP: assert property (@(posedge clk) disable iff (rst)
        (evt.tgt && mode_q[MB_WRAP_TGT]) |=> (count == '0 && mode_q[MB_HIT_TGT])); // R3
    AST_RD_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (rd_mode && !wr_mode && !evt.tgt && !evt.ovf) |=> (mode_q[MB_HIT_OVF:MB_HIT_TGT] == 2'b00)); // R7
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (rst)
        evt.ovf |=> (count == '0 && mode_q[MB_HIT_OVF])); // R4
endmodule

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_tick = 1'b0, line_tick = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rdata0, rdata2;
    logic [7:0]  irq0, irq2;

    always #(HALF) clk = ~clk;

    tmr_channel #(.CHAN_ID(0)) dut (
        .clk(clk), .rst(rst), .pix_tick(pix_tick), .line_tick(line_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .irq_status(irq0)
    );
    tmr_channel #(.CHAN_ID(2)) dut2 (
        .clk(clk), .rst(rst), .pix_tick(pix_tick), .line_tick(line_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rdata2), .irq_status(irq2)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int np0 = 0, np2 = 0, last0 = 0, last2 = 0;
    logic [15:0] r0, r2;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: index 0 models channel 0, index 1 models channel 2
    int m_cnt[2], m_tgt[2], m_mode[2], m_pre[2], m_fired[2], m_irq[2];
    int tk, tg, ov, fire, inc, id;

    function automatic int bitof(int v, int b);
        return (v >> b) & 1;
    endfunction

    function automatic int exp_rd(int k);
        if (!bus_rd) return 0;
        case (bus_addr)
            2'd0: return m_cnt[k];
            2'd1: return m_mode[k];
            2'd2: return m_tgt[k];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = 0; m_tgt[k] = 0; m_mode[k] = 0;
                m_pre[k] = 0; m_fired[k] = 0; m_irq[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                id = (k == 0) ? 0 : 2;
                if (id == 0)
                    tk = bitof(m_mode[k], 8) ? int'(pix_tick) : 1;
                else begin
                    tk = bitof(m_mode[k], 9) ? int'(m_pre[k] == 7) : 1;
                    if (bitof(m_mode[k], 0)) tk = 0;
                    if (bitof(m_mode[k], 9) && !bitof(m_mode[k], 0))
                        m_pre[k] = (m_pre[k] + 1) % 8;
                end
                if (bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) tk = 0;
                inc = (m_cnt[k] + 1) & 16'hFFFF;
                tg = int'(tk != 0 && inc == m_tgt[k]);
                ov = int'(tk != 0 && m_cnt[k] == 16'hFFFF);
                fire = int'(((tg != 0 && bitof(m_mode[k], 4) != 0) || (ov != 0 && bitof(m_mode[k], 5) != 0))
                            && (bitof(m_mode[k], 6) != 0 || m_fired[k] == 0));
                m_irq[k] = (fire != 0) ? (16 << id) : 0;
                if (fire != 0) m_fired[k] = 1;
                if (tk != 0) m_cnt[k] = (ov != 0 || (tg != 0 && bitof(m_mode[k], 3) != 0)) ? 0 : inc;
                if (bus_rd && bus_addr == 2'd1) m_mode[k] = m_mode[k] & 16'hE7FF;
                if (tg != 0) m_mode[k] = m_mode[k] | 16'h0800;
                if (ov != 0) m_mode[k] = m_mode[k] | 16'h1000;
                if (bus_wr) begin
                    case (bus_addr)
                        2'd0: m_cnt[k] = int'(bus_wdata);
                        2'd2: m_tgt[k] = int'(bus_wdata);
                        2'd1: begin
                            m_mode[k] = int'(bus_wdata) & 16'hE7FF;
                            m_cnt[k] = 0; m_pre[k] = 0; m_fired[k] = 0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-clock comparison, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R5", "irq_status ch0", int'(irq0), m_irq[0]);
            chk("R5", "irq_status ch2", int'(irq2), m_irq[1]);
            if (bus_rd) begin
                chk("R2", "rdata ch0 after edge", int'(rdata0), exp_rd(0));
                chk("R2", "rdata ch2 after edge", int'(rdata2), exp_rd(1));
            end
            if (irq0 != 0) begin np0++; last0 = int'(irq0); end
            if (irq2 != 0) begin np2++; last2 = int'(irq2); end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        bus_addr = a; bus_rd = 1'b1;
        #1.25;
        r0 = rdata0; r2 = rdata2;
        chk("R2", "read ch0 vs model", int'(r0), exp_rd(0));
        chk("R2", "read ch2 vs model", int'(r2), exp_rd(1));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_pulses();
        np0 = 0; np2 = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(2'd0); chk("R1", "count after reset ch0", int'(r0), 0); chk("R1", "count after reset ch2", int'(r2), 0);
        rd(2'd1); chk("R1", "mode after reset", int'(r0), 0);
        rd(2'd2); chk("R1", "target after reset", int'(r2), 0);
        chk("R1", "irq after reset", int'(irq0 | irq2), 0);

        // R2: free counting on system clock
        wr(2'd1, 16'h0000); idle(10); rd(2'd0);
        chk("R2", "sysclk count ch0", int'(r0), 10); chk("R2", "sysclk count ch2", int'(r2), 10);

        // R11: count load and target write
        wr(2'd0, 16'h1234); rd(2'd0);
        chk("R11", "count load ch0", int'(r0), 16'h1234);
        wr(2'd2, 16'd100); rd(2'd0);
        chk("R11", "count after target write", int'(r0), 16'h1236);
        rd(2'd2); chk("R11", "target readback", int'(r2), 100);

        // R3 + R5: wrap at target with repeating interrupt
        wr(2'd2, 16'd5); wr(2'd1, 16'h0058); clr_pulses(); idle(20);
        chk("R3", "repeat irq pulses ch0", np0, 4); chk("R3", "repeat irq pulses ch2", np2, 4);
        chk("R5", "channel code ch0", last0, 8'h10); chk("R5", "channel code ch2", last2, 8'h40);
        // R7: read returns flag, then clears it
        rd(2'd1); chk("R7", "mode with hit flag", int'(r0), 16'h0858);
        rd(2'd1); chk("R7", "mode after read clear", int'(r0), 16'h0058);

        // R6: one-shot, R8: re-arm on mode write
        wr(2'd1, 16'h0018); clr_pulses(); idle(20);
        chk("R6", "one-shot pulses", np0, 1);
        wr(2'd1, 16'h0018); clr_pulses(); idle(6);
        chk("R8", "re-armed pulses", np0, 1);
        rd(2'd1); chk("R8", "mode write clears flags", int'(r0) & 16'h1000, 0);

        // R4: overflow and pass-through target
        wr(2'd1, 16'h0060); wr(2'd0, 16'hFFF0); clr_pulses(); idle(18);
        chk("R4", "overflow irq pulses", np0, 1);
        rd(2'd1); chk("R4", "overflow flag", int'(r0), 16'h1060);
        idle(3); rd(2'd0); chk("R4", "no wrap at target", int'(r0), 6);
        rd(2'd1); chk("R4", "target flag without wrap", int'(r0), 16'h0860);

        // R9: divide by 8 and stop (channel 2 only)
        wr(2'd1, 16'h0200); idle(16); rd(2'd0);
        chk("R9", "div8 count ch2", int'(r2), 2); chk("R9", "div8 ignored ch0", int'(r0), 16);
        wr(2'd1, 16'h0001); idle(10); rd(2'd0);
        chk("R9", "stopped ch2", int'(r2), 0); chk("R9", "stop ignored ch0", int'(r0), 10);

        // R10: external pixel tick on channel 0
        wr(2'd1, 16'h0100);
        repeat (3) begin
            pix_tick = 1'b1; @(negedge clk); pix_tick = 1'b0; @(negedge clk);
        end
        rd(2'd0);
        chk("R10", "pixel ticks ch0", int'(r0), 3); chk("R10", "bit8 ignored ch2", int'(r2), 6);

        idle(2);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule